// File: doc/BRIEF.md
# Correlator Accumulation Status Register

This block keeps the status and interrupt flags that a twelve-channel correlator reports to its host. Each channel supplies a dump strobe, a dither early/late code and an enable. The block tracks, per channel, whether fresh accumulated data is waiting, whether a dump overwrote data that was never read, and which code type the latest dump carried. A measurement TIC strobe drives a TIC flag and a measurement interrupt flag. The interrupt flag can also fire a fixed lead time ahead of the next TIC, so that software can schedule work before the measurement arrives.

The per-channel flags are not shown live. Three read-only status words show a snapshot that is refreshed only on a rising edge of the accumulation interrupt input or on a write to any status word address. Turning a channel off clears its bits at once. The host uses a small register bus. Writes carry no data, only an address. Reading the second word clears the TIC and measurement flags. Writes to per-channel reset addresses, or to a single all-channels address, clear the missed-data state. A software reset clears the channel state but keeps the two timing flags. Only the active-low hardware reset clears everything.

Top module: `acc_stat_top`

## Requirements
- R1: The active-low hardware reset clears every flag, so words A (address 0), B (address 1) and C (address 2) all read 0x0000.
- R2: An enabled dump on channel c marks data pending. Bit c of word A shows this only after a snapshot event, which is either a rising edge of the accumulation interrupt input or a write to address 0, 1 or 2. Between snapshot events, a held-high interrupt input changes nothing.
- R3: A read at address 16+c clears channel c's pending state. A dump in the same cycle as that read leaves the data pending and does not count as missed.
- R4: A dump while channel c has data pending, with no read of 16+c in that cycle, sets the missed flag, which appears as bit c of word B after a snapshot. The flag survives accumulator reads. Only a write to 32+c or to the all-channels address 48 clears it. The write to 32+c leaves other channels untouched.
- R5: Every enabled dump captures the channel's early/late input, with 1 meaning early. Word C carries these bits, channel c in bit c, and bits 15..12 read 0.
- R6: While a channel's enable is low, its bits in words A, B and C read 0 in the same cycle, with no clock edge needed. Dumps on that channel are ignored, and re-enabling it does not bring back old values.
- R7: A TIC strobe sets bit 15 of word B. A read strobe at address 1 clears it. If a TIC arrives in the same cycle as that read, the flag stays set.
- R8: Bit 14 of word B is set by a TIC only while interrupts are enabled. When the programmed TIC period P (in clock cycles) is larger than LEAD_CYC, the bit is also set LEAD_CYC cycles before the next expected TIC, which is P-LEAD_CYC cycles after the last one. When P is at most LEAD_CYC, no early set occurs. Reading address 1 clears the bit.
- R9: A software reset clears all per-channel live and snapshot state but leaves bits 15 and 14 of word B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| sw_rst_i | input | 1 | Software reset pulse |
| tic_i | input | 1 | Measurement TIC strobe |
| int_en_i | input | 1 | Interrupt enable for the measurement flag |
| tic_per_i | input | CNTW | TIC period in clock cycles |
| acc_int_i | input | 1 | Accumulation interrupt level, active on rising edge |
| ch_en_i | input | NCH | Per-channel enable |
| ch_dump_i | input | NCH | Per-channel dump strobe |
| ch_early_i | input | NCH | Per-channel early(1)/late(0) code at dump |
| wr_i | input | 1 | Bus write strobe, data ignored |
| rd_i | input | 1 | Bus read strobe, applies read side effects |
| addr_i | input | 6 | Bus address |
| rd_data_o | output | 16 | Status word selected by addr_i, combinational |

## Verification
The bench targets the cases where a set event and a clear land in the same cycle. These are a dump together with its accumulator read, and a TIC together with the status read. A design that let the clear win would lose data, or would flag a miss that never happened. The bench checks that a held-high interrupt level does not refresh the snapshot. A level-triggered design would show new data early. It checks disable-masking without a clock edge, which catches a design that waits for the next snapshot. It checks the exact cycle of the early measurement flag, so an off-by-one in the lead counter shows up. A software reset must keep the timing flags, so a design that ties both resets together fails that check.

// File: rtl/acc_stat_pkg.sv
`timescale 1ns/1ps
package acc_stat_pkg;
  localparam int AW = 6;
  localparam int DW = 16;

  localparam logic [AW-1:0] ADR_WORD_A   = 6'd0;
  localparam logic [AW-1:0] ADR_WORD_B   = 6'd1;
  localparam logic [AW-1:0] ADR_WORD_C   = 6'd2;
  localparam logic [AW-1:0] ADR_ACC_BASE = 6'd16;
  localparam logic [AW-1:0] ADR_RST_BASE = 6'd32;
  localparam logic [AW-1:0] ADR_RST_ALL  = 6'd48;

  // address of channel ch inside a per-channel window
  function automatic logic [AW-1:0] chan_addr(input logic [AW-1:0] base, input int ch);
    return base + AW'(ch);
  endfunction

  // early measurement event: lead cycles ahead of the next TIC
  // cnt counts cycles since the last TIC, 0 in the first cycle after it
  function automatic logic lead_hit(input int unsigned cnt, input int unsigned per,
                                    input int unsigned lead);
    return (per > lead) && (cnt == per - lead - 1);
  endfunction
endpackage

// File: rtl/acc_stat_chan.sv
`timescale 1ns/1ps
module acc_stat_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic en,
  input  logic dump,
  input  logic early,
  input  logic acc_rd,
  input  logic rst_wr,
  input  logic snap_evt,
  output logic dump_eff_o,
  output logic pend_o,
  output logic miss_o,
  output logic snap_new_o,
  output logic snap_miss_o,
  output logic snap_el_o
);
  logic pend_q, miss_q, el_q;
  logic snap_new_q, snap_miss_q, snap_el_q;
  logic dump_eff;

  assign dump_eff = dump & en;

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst || !en) begin
      pend_q      <= 1'b0;
      miss_q      <= 1'b0;
      el_q        <= 1'b0;
      snap_new_q  <= 1'b0;
      snap_miss_q <= 1'b0;
      snap_el_q   <= 1'b0;
    end else begin
      // set wins over read or reset write
      pend_q <= dump_eff | (pend_q & ~acc_rd & ~rst_wr);
      miss_q <= (dump_eff & pend_q & ~acc_rd) | (miss_q & ~rst_wr);
      if (dump_eff)    el_q <= early;
      else if (rst_wr) el_q <= 1'b0;
      if (snap_evt) begin
        snap_new_q  <= pend_q;
        snap_miss_q <= miss_q;
        snap_el_q   <= el_q;
      end
    end
  end

  assign dump_eff_o  = dump_eff;
  assign pend_o      = pend_q;
  assign miss_o      = miss_q;
  assign snap_new_o  = snap_new_q;
  assign snap_miss_o = snap_miss_q;
  assign snap_el_o   = snap_el_q;
endmodule

// File: rtl/acc_stat_meas.sv
`timescale 1ns/1ps
module acc_stat_meas #(
  parameter int CNTW     = 16,
  parameter int LEAD_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tic,
  input  logic            int_en,
  input  logic [CNTW-1:0] per,
  input  logic            flag_rd,
  output logic            tic_flag_o,
  output logic            meas_flag_o,
  output logic            pre_evt_o
);
  import acc_stat_pkg::*;

  logic [CNTW-1:0] cnt_q;
  logic            tic_flag_q, meas_flag_q, pre_evt;

  assign pre_evt = lead_hit(32'(cnt_q), 32'(per), LEAD_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      tic_flag_q  <= 1'b0;
      meas_flag_q <= 1'b0;
    end else begin
      if (tic)              cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      tic_flag_q  <= tic | (tic_flag_q & ~flag_rd);
      meas_flag_q <= (int_en & (tic | pre_evt)) | (meas_flag_q & ~flag_rd);
    end
  end

  assign tic_flag_o  = tic_flag_q;
  assign meas_flag_o = meas_flag_q;
  assign pre_evt_o   = pre_evt;
endmodule

// File: rtl/acc_stat_top.sv
`timescale 1ns/1ps
module acc_stat_top #(
  parameter int NCH      = 12,
  parameter int CNTW     = 16,
  parameter int LEAD_CYC = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_rst_i,
  input  logic                        tic_i,
  input  logic                        int_en_i,
  input  logic [CNTW-1:0]             tic_per_i,
  input  logic                        acc_int_i,
  input  logic [NCH-1:0]              ch_en_i,
  input  logic [NCH-1:0]              ch_dump_i,
  input  logic [NCH-1:0]              ch_early_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [acc_stat_pkg::AW-1:0] addr_i,
  output logic [acc_stat_pkg::DW-1:0] rd_data_o
);
  import acc_stat_pkg::*;

  localparam int B_TIC  = DW - 1;
  localparam int B_MEAS = DW - 2;

  logic [NCH-1:0] acc_rd, rst_wr, dump_eff;
  logic [NCH-1:0] pend_v, miss_v, snap_new_v, snap_miss_v, snap_el_v;
  logic           acc_int_q, acc_rise, status_wr, snap_evt, rst_any_wr;
  logic           flag_rd, tic_flag, meas_flag, pre_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_int_q <= 1'b0;
    else        acc_int_q <= acc_int_i;
  end

  assign acc_rise   = acc_int_i & ~acc_int_q;
  assign status_wr  = wr_i && (addr_i == ADR_WORD_A || addr_i == ADR_WORD_B ||
                               addr_i == ADR_WORD_C);
  assign snap_evt   = acc_rise | status_wr;
  assign flag_rd    = rd_i && (addr_i == ADR_WORD_B);
  assign rst_any_wr = |rst_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign acc_rd[c] = rd_i && (addr_i == chan_addr(ADR_ACC_BASE, c));
    assign rst_wr[c] = wr_i && (addr_i == chan_addr(ADR_RST_BASE, c) ||
                                addr_i == ADR_RST_ALL);
    acc_stat_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst_i),
      .en         (ch_en_i[c]),
      .dump       (ch_dump_i[c]),
      .early      (ch_early_i[c]),
      .acc_rd     (acc_rd[c]),
      .rst_wr     (rst_wr[c]),
      .snap_evt   (snap_evt),
      .dump_eff_o (dump_eff[c]),
      .pend_o     (pend_v[c]),
      .miss_o     (miss_v[c]),
      .snap_new_o (snap_new_v[c]),
      .snap_miss_o(snap_miss_v[c]),
      .snap_el_o  (snap_el_v[c])
    );
  end

  acc_stat_meas #(.CNTW(CNTW), .LEAD_CYC(LEAD_CYC)) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .tic        (tic_i),
    .int_en     (int_en_i),
    .per        (tic_per_i),
    .flag_rd    (flag_rd),
    .tic_flag_o (tic_flag),
    .meas_flag_o(meas_flag),
    .pre_evt_o  (pre_evt)
  );

  // disabled channels read zero without waiting for a clock edge
  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADR_WORD_A: rd_data_o[NCH-1:0] = snap_new_v & ch_en_i;
      ADR_WORD_B: begin
        rd_data_o[NCH-1:0] = snap_miss_v & ch_en_i;
        rd_data_o[B_TIC]   = tic_flag;
        rd_data_o[B_MEAS]  = meas_flag;
      end
      ADR_WORD_C: rd_data_o[NCH-1:0] = snap_el_v & ch_en_i;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_stat_chk.sv
`timescale 1ns/1ps
module acc_stat_chk #(
  parameter int NCH = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sw_rst_i,
  input logic                        tic_i,
  input logic                        int_en_i,
  input logic [NCH-1:0]              ch_en_i,
  input logic [acc_stat_pkg::AW-1:0] addr_i,
  input logic [acc_stat_pkg::DW-1:0] rd_data_o,
  input logic [NCH-1:0]              dump_eff,
  input logic [NCH-1:0]              pend_v,
  input logic [NCH-1:0]              miss_v,
  input logic [NCH-1:0]              snap_new_v,
  input logic [NCH-1:0]              snap_miss_v,
  input logic [NCH-1:0]              snap_el_v,
  input logic                        snap_evt,
  input logic                        rst_any_wr,
  input logic                        tic_flag,
  input logic                        meas_flag
);
  import acc_stat_pkg::*;

  // R7
  tic_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tic_i |=> tic_flag);

  // R8
  meas_on_tic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tic_i && int_en_i) |=> meas_flag);

  // R2
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_evt && !sw_rst_i && (&ch_en_i)) |=>
      ($stable(snap_new_v) && $stable(snap_miss_v) && $stable(snap_el_v)));

  // R3
  dump_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dump_eff) && !sw_rst_i) |=> ((pend_v & $past(dump_eff)) == $past(dump_eff)));

  // R4
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst_i && !rst_any_wr) |=>
      (($past(miss_v) & $past(ch_en_i) & ~miss_v) == '0));

  // R6
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ch_en_i)) |=>
      (((snap_new_v | snap_miss_v | snap_el_v) & ~$past(ch_en_i)) == '0));

  // R5
  word_c_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADR_WORD_C) |-> (rd_data_o[DW-1:NCH] == '0));
endmodule

bind acc_stat_top acc_stat_chk #(.NCH(NCH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_rst_i   (sw_rst_i),
  .tic_i      (tic_i),
  .int_en_i   (int_en_i),
  .ch_en_i    (ch_en_i),
  .addr_i     (addr_i),
  .rd_data_o  (rd_data_o),
  .dump_eff   (dump_eff),
  .pend_v     (pend_v),
  .miss_v     (miss_v),
  .snap_new_v (snap_new_v),
  .snap_miss_v(snap_miss_v),
  .snap_el_v  (snap_el_v),
  .snap_evt   (snap_evt),
  .rst_any_wr (rst_any_wr),
  .tic_flag   (tic_flag),
  .meas_flag  (meas_flag)
);

// File: tb/acc_stat_top_tb.sv
`timescale 1ns/1ps
module acc_stat_top_tb_top;
  localparam int NCH  = 12;
  localparam int CNTW = 16;
  localparam int LEAD = 20;

  logic            clk = 1'b0;
  logic            rst_n, sw_rst_i, tic_i, int_en_i, acc_int_i, wr_i, rd_i;
  logic [CNTW-1:0] tic_per_i;
  logic [NCH-1:0]  ch_en_i, ch_dump_i, ch_early_i;
  logic [5:0]      addr_i;
  logic [15:0]     rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_stat_top #(.NCH(NCH), .CNTW(CNTW), .LEAD_CYC(LEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst_i), .tic_i(tic_i),
    .int_en_i(int_en_i), .tic_per_i(tic_per_i), .acc_int_i(acc_int_i),
    .ch_en_i(ch_en_i), .ch_dump_i(ch_dump_i), .ch_early_i(ch_early_i),
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .rd_data_o(rd_data_o)
  );

  // {dump mask, early inputs, expected word C}
  localparam logic [35:0] VEC [4] = '{
    {12'h00F, 12'h005, 12'h005},
    {12'hF00, 12'hA5A, 12'hA00},
    {12'h0F0, 12'hFFF, 12'h0F0},
    {12'h555, 12'h3C3, 12'h141}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    ch_dump_i = '0; tic_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0; sw_rst_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic wr(input logic [5:0] a);
    addr_i = a; wr_i = 1'b1; step();
  endtask

  task automatic dump(input logic [NCH-1:0] m, input logic [NCH-1:0] e);
    ch_dump_i = m; ch_early_i = e; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; sw_rst_i = 0; tic_i = 0; int_en_i = 0; acc_int_i = 0;
    wr_i = 0; rd_i = 0; addr_i = '0; tic_per_i = 16'd40;
    ch_en_i = '1; ch_dump_i = '0; ch_early_i = '0;
    repeat (3) step();
    rst_n = 1'b1; step();

    // R1 reset state
    peek(6'd0, d); chk("R1 word A", d, 16'h0000);
    peek(6'd1, d); chk("R1 word B", d, 16'h0000);
    peek(6'd2, d); chk("R1 word C", d, 16'h0000);

    // table walk: R2, R4, R5
    foreach (VEC[i]) begin
      wr(6'd48);
      dump(VEC[i][35:24], VEC[i][23:12]);
      wr(6'd0);
      peek(6'd0, d); chk("R2 vec word A", d, {4'h0, VEC[i][35:24]});
      peek(6'd2, d); chk("R5 vec word C", d, {4'h0, VEC[i][11:0]});
      peek(6'd1, d); chk("R4 vec no miss", {4'h0, d[11:0]}, 16'h0000);
      dump(VEC[i][35:24], VEC[i][23:12]);
      wr(6'd2);
      peek(6'd1, d); chk("R4 vec miss", {4'h0, d[11:0]}, {4'h0, VEC[i][35:24]});
    end

    // R2 snapshot only on events
    wr(6'd48); wr(6'd1);
    dump(12'h008, 12'h000);
    peek(6'd0, d); chk("R2 held before event", d, 16'h0000);
    acc_int_i = 1'b1; step();
    peek(6'd0, d); chk("R2 rising edge", d, 16'h0008);
    dump(12'h010, 12'h000); step();
    peek(6'd0, d); chk("R2 level no refresh", d, 16'h0008);
    acc_int_i = 1'b0; step();
    acc_int_i = 1'b1; step();
    peek(6'd0, d); chk("R2 second edge", d, 16'h0018);

    // R3 read clears, dump wins over read
    addr_i = 6'd19; rd_i = 1'b1; step();
    wr(6'd0);
    peek(6'd0, d); chk("R3 read clears", d, 16'h0010);
    dump(12'h020, 12'h000);
    addr_i = 6'd21; rd_i = 1'b1; ch_dump_i = 12'h020; step();
    wr(6'd0);
    peek(6'd0, d); chk("R3 dump wins", d, 16'h0030);
    peek(6'd1, d); chk("R3 no false miss", {4'h0, d[11:0]}, 16'h0000);

    // R4 sticky missed flag
    dump(12'h010, 12'h000);
    wr(6'd1);
    peek(6'd1, d); chk("R4 miss set", {4'h0, d[11:0]}, 16'h0010);
    addr_i = 6'd20; rd_i = 1'b1; step();
    wr(6'd1);
    peek(6'd1, d); chk("R4 read keeps miss", {4'h0, d[11:0]}, 16'h0010);
    wr(6'd35); wr(6'd1);
    peek(6'd1, d); chk("R4 other reset", {4'h0, d[11:0]}, 16'h0010);
    wr(6'd36); wr(6'd1);
    peek(6'd1, d); chk("R4 own reset", {4'h0, d[11:0]}, 16'h0000);

    // R6 disable masks at once
    dump(12'h004, 12'h004); dump(12'h004, 12'h004);
    wr(6'd0);
    peek(6'd2, d); chk("R6 set before", {4'h0, d[11:0]} & 16'h0004, 16'h0004);
    ch_en_i[2] = 1'b0;
    peek(6'd0, d); chk("R6 A immediate", d & 16'h0004, 16'h0000);
    peek(6'd1, d); chk("R6 B immediate", d & 16'h0004, 16'h0000);
    peek(6'd2, d); chk("R6 C immediate", d & 16'h0004, 16'h0000);
    dump(12'h004, 12'h004); step();
    ch_en_i[2] = 1'b1; step();
    wr(6'd0);
    peek(6'd0, d); chk("R6 no revive A", d & 16'h0004, 16'h0000);
    peek(6'd1, d); chk("R6 no revive B", d & 16'h0004, 16'h0000);

    // R7 TIC flag
    tic_i = 1'b1; step();
    peek(6'd1, d); chk("R7 tic set", d & 16'hC000, 16'h8000);
    addr_i = 6'd1; rd_i = 1'b1; step();
    peek(6'd1, d); chk("R7 read clears", d & 16'hC000, 16'h0000);
    addr_i = 6'd1; rd_i = 1'b1; tic_i = 1'b1; step();
    peek(6'd1, d); chk("R7 tic wins", d & 16'h8000, 16'h8000);
    addr_i = 6'd1; rd_i = 1'b1; step();

    // R8 measurement flag and lead event
    int_en_i = 1'b1; tic_per_i = 16'd40; tic_i = 1'b1; step();
    peek(6'd1, d); chk("R8 tic sets meas", d & 16'h4000, 16'h4000);
    addr_i = 6'd1; rd_i = 1'b1; step();
    repeat (18) step();
    peek(6'd1, d); chk("R8 not yet", d & 16'h4000, 16'h0000);
    step();
    peek(6'd1, d); chk("R8 lead event", d & 16'h4000, 16'h4000);
    tic_per_i = 16'd10; tic_i = 1'b1; step();
    addr_i = 6'd1; rd_i = 1'b1; step();
    repeat (30) step();
    peek(6'd1, d); chk("R8 short period", d & 16'h4000, 16'h0000);

    // R9 software reset keeps timing flags
    tic_i = 1'b1; step();
    dump(12'h002, 12'h002); dump(12'h002, 12'h002);
    wr(6'd0);
    sw_rst_i = 1'b1; step();
    peek(6'd1, d); chk("R9 B after soft reset", d, 16'hC000);
    peek(6'd0, d); chk("R9 A after soft reset", d, 16'h0000);

    // R1 hardware reset clears all
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    peek(6'd1, d); chk("R1 B after hard reset", d, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule